// File: doc/BRIEF.md
# Two-Mode Successive-Approximation Controller

This block sequences a 10-bit successive-approximation converter for a column readout that works in two passes. In the coarse pass it samples the input and then resolves only the upper bits of the code, with every lower bit left at zero. In the fine pass the upper bits are not searched again. They are taken from a code supplied from outside, which is normally the rounded mean of earlier coarse passes. That code is placed in the top of the DAC word, and the search covers only the bits below it. Skipping the already-known upper trials makes each fine conversion four clocks shorter than a full one.

A start pulse begins a conversion. The mode and the preload code are captured when the pulse is accepted. The block then holds a sample phase whose length comes from an input setting, spends one cycle setting up the DAC register, and runs one trial per clock. Each trial reads the comparator bit. A single-cycle done pulse marks the finished result. The capacitor array, the comparator and any redundancy weighting lie outside this block.

Top module: `sar_ctl`

## Requirements
- R1: While reset is active and after it is released, `dac_o`, `result_o`, `sample_o` and `done_o` are all zero.
- R2: `start_i` is acted on only while the controller is idle. A start during a conversion has no effect, and mode and preload changes after an accepted start do not alter that conversion.
- R3: `sample_o` rises in the cycle after an accepted start and stays high for `smp_len_i` cycles. A setting of 0 gives one cycle. `sample_o` and `done_o` are never high together.
- R4: Exactly one setup cycle follows sampling, with `sample_o` low and `dac_o` unchanged. In it the DAC register is cleared for a coarse conversion (`fine_i`=0) or loaded with the preload code in bits 9:6 for a fine conversion (`fine_i`=1).
- R5: In each trial cycle `dac_o` shows the bits kept so far with the trial bit set. The bit is kept if `comp_i` is 1 at the end of the cycle and cleared otherwise. Trials go from the most to the least significant bit.
- R6: A coarse conversion runs 5 trials on bits 9 down to 5. Bits 4:0 of the DAC word stay zero.
- R7: A fine conversion runs 6 trials on bits 5 down to 0, and bits 9:6 stay at the loaded preload code. The conversion lasts 11+H−4 cycles from the first sample cycle to the last trial.
- R8: A preload code above 15 is clipped to 15 before it is loaded.
- R9: `done_o` is high for exactly one cycle, directly after the last trial. In that cycle `result_o` holds the resolved bits right-aligned and zero-extended: the 5-bit coarse code, or the 6-bit fine code.
- R10: Between conversions `result_o` and `dac_o` keep their final values until the next conversion changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request pulse |
| fine_i | input | 1 | 1 selects fine mode, 0 selects coarse mode |
| preload_i | input | 6 | Coarse code to load for fine mode (clipped to 4 bits) |
| smp_len_i | input | 4 | Sample-phase length in clocks |
| comp_i | input | 1 | Comparator decision for the current trial |
| dac_o | output | 10 | DAC control word |
| sample_o | output | 1 | High during the sample phase |
| result_o | output | 10 | Right-aligned result code |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The embedded assertions check on every cycle that done is a single-cycle pulse and never overlaps sampling, and that the result holds after done. They also check that the latched mode cannot change mid-conversion, that a trial is followed only by another trial or by completion, that the coarse setup clears the DAC register, and that the preloaded upper bits stay fixed through fine trials. The exact trial order, the DAC word in each cycle, the sample length (including the zero setting), the clipping of large preload codes and the right alignment of both result widths are shown only by the bench. The bench drives a comparator model from a held analog level and compares every cycle against a reference trace.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SAMPLE  = 3'd1,
      ST_PRELOAD = 3'd2,
      ST_TRIAL   = 3'd3,
      ST_DONE    = 3'd4
   } sar_state_e;
endpackage

// File: rtl/sar_clip.sv
module sar_clip #(
   parameter int PIN_W  = 6,
   parameter int LOAD_W = 4
) (
   input  logic [PIN_W-1:0]  code_i,
   output logic [LOAD_W-1:0] code_o
);
   generate
      if (PIN_W > LOAD_W) begin : g_sat
         logic over;
         assign over   = |code_i[PIN_W-1:LOAD_W];
         assign code_o = over ? {LOAD_W{1'b1}} : code_i[LOAD_W-1:0];
      end else begin : g_pass
         assign code_o = LOAD_W'(code_i);
      end
   endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int CRS_W  = 5,
   parameter int LOAD_W = 4,
   parameter int SMP_W  = 4,
   localparam int PTR_W  = $clog2(RES_W),
   localparam int FINE_W = RES_W - LOAD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fine_i,
   input  logic [SMP_W-1:0] smp_len_i,
   output sar_state_e       state_o,
   output logic             fine_o,
   output logic [PTR_W-1:0] ptr_o,
   output logic             last_o
);
   sar_state_e       state_q;
   logic [SMP_W-1:0] cnt_q;
   logic [PTR_W-1:0] ptr_q;
   logic             fine_q;
   logic [PTR_W-1:0] stop_ptr;

   assign stop_ptr = fine_q ? PTR_W'(0) : PTR_W'(RES_W - CRS_W);
   assign last_o   = (state_q == ST_TRIAL) && (ptr_q == stop_ptr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ptr_q   <= '0;
         fine_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  fine_q  <= fine_i;
                  cnt_q   <= smp_len_i;
                  state_q <= ST_SAMPLE;
               end
            end
            ST_SAMPLE: begin
               if (cnt_q <= SMP_W'(1)) state_q <= ST_PRELOAD;
               else                    cnt_q   <= cnt_q - SMP_W'(1);
            end
            ST_PRELOAD: begin
               ptr_q   <= fine_q ? PTR_W'(FINE_W - 1) : PTR_W'(RES_W - 1);
               state_q <= ST_TRIAL;
            end
            ST_TRIAL: begin
               if (ptr_q == stop_ptr) state_q <= ST_DONE;
               else                   ptr_q   <= ptr_q - PTR_W'(1);
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign fine_o  = fine_q;
   assign ptr_o   = ptr_q;

   AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(fine_q)); // R2
   AST_TRIAL_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRIAL) |=> (state_q == ST_TRIAL || state_q == ST_DONE)); // R2
endmodule

// File: rtl/sar_reg.sv
module sar_reg
   import sar_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int CRS_W  = 5,
   parameter int LOAD_W = 4,
   localparam int PTR_W  = $clog2(RES_W),
   localparam int FINE_W = RES_W - LOAD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sar_state_e        state_i,
   input  logic              fine_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic              last_i,
   input  logic              comp_i,
   input  logic [LOAD_W-1:0] load_i,
   output logic [RES_W-1:0]  dac_o,
   output logic [RES_W-1:0]  result_o
);
   logic [RES_W-1:0] dac_q, res_q, try_bit, nxt_dac;

   always_comb begin
      try_bit = '0;
      if (state_i == ST_TRIAL) try_bit = RES_W'(1) << ptr_i;
      nxt_dac = comp_i ? (dac_q | try_bit) : dac_q;
   end

   assign dac_o = dac_q | try_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_q <= '0;
         res_q <= '0;
      end else begin
         if (state_i == ST_PRELOAD)
            dac_q <= fine_i ? {load_i, {FINE_W{1'b0}}} : '0;
         else if (state_i == ST_TRIAL)
            dac_q <= nxt_dac;
         if (last_i)
            res_q <= fine_i ? RES_W'(nxt_dac[FINE_W-1:0])
                            : RES_W'(nxt_dac[RES_W-1 -: CRS_W]);
      end
   end

   assign result_o = res_q;

   AST_COARSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_PRELOAD && !fine_i) |=> (dac_q == '0)); // R6
   AST_FINE_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_TRIAL && fine_i) |=> $stable(dac_q[RES_W-1 -: LOAD_W])); // R7
endmodule

// File: rtl/sar_ctl.sv
module sar_ctl
   import sar_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int CRS_W  = 5,
   parameter int LOAD_W = 4,
   parameter int PIN_W  = 6,
   parameter int SMP_W  = 4,
   localparam int PTR_W = $clog2(RES_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fine_i,
   input  logic [PIN_W-1:0] preload_i,
   input  logic [SMP_W-1:0] smp_len_i,
   input  logic             comp_i,
   output logic [RES_W-1:0] dac_o,
   output logic             sample_o,
   output logic [RES_W-1:0] result_o,
   output logic             done_o
);
   if (CRS_W > RES_W || CRS_W < 1) begin : g_bad_crs
      $error("coarse width must lie in 1..RES_W");
   end
   if (LOAD_W >= RES_W || LOAD_W < 1) begin : g_bad_load
      $error("preload width must leave at least one fine bit");
   end
   if (PIN_W < LOAD_W) begin : g_bad_pin
      $error("preload input narrower than its field");
   end

   sar_state_e        state;
   logic              fine_q, last;
   logic [PTR_W-1:0]  ptr;
   logic [PIN_W-1:0]  pre_q;
   logic [LOAD_W-1:0] pre_clip;

   always_ff @(posedge clk) begin
      if (!rst_n)                              pre_q <= '0;
      else if (state == ST_IDLE && start_i)    pre_q <= preload_i;
   end

   sar_clip #(.PIN_W(PIN_W), .LOAD_W(LOAD_W)) u_clip (
      .code_i(pre_q), .code_o(pre_clip));

   sar_seq #(.RES_W(RES_W), .CRS_W(CRS_W), .LOAD_W(LOAD_W), .SMP_W(SMP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fine_i(fine_i),
      .smp_len_i(smp_len_i), .state_o(state), .fine_o(fine_q),
      .ptr_o(ptr), .last_o(last));

   sar_reg #(.RES_W(RES_W), .CRS_W(CRS_W), .LOAD_W(LOAD_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .state_i(state), .fine_i(fine_q),
      .ptr_i(ptr), .last_i(last), .comp_i(comp_i), .load_i(pre_clip),
      .dac_o(dac_o), .result_o(result_o));

   assign sample_o = (state == ST_SAMPLE);
   assign done_o   = (state == ST_DONE);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_SAMPLE_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_o && done_o)); // R3
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> $stable(result_o)); // R10
endmodule

// File: tb/sim_sar_ctl.sv
module sim_sar_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, fine = 1'b0, comp;
   logic [5:0] pre = '0;
   logic [3:0] slen = '0;
   logic [9:0] dac, res;
   logic       smp, done;
   int         vin = 0;
   int         n_cmp = 0, n_bad = 0;
   int         last_dac = 0, last_res = 0;
   int         q_dac[$], q_res[$];
   bit         q_smp[$], q_done[$];
   string      q_tag[$];

   always #2 clk = ~clk;

   assign comp = (int'(dac) <= vin);

   sar_ctl u0 (.clk(clk), .rst_n(rst_n), .start_i(start), .fine_i(fine),
      .preload_i(pre), .smp_len_i(slen), .comp_i(comp), .dac_o(dac),
      .sample_o(smp), .result_o(res), .done_o(done));

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic push(bit s, int d, bit dn, int r, string t);
      q_smp.push_back(s); q_dac.push_back(d); q_done.push_back(dn);
      q_res.push_back(r); q_tag.push_back(t);
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk("R10 idle sample", int'(smp), 0);
      chk("R10 idle done", int'(done), 0);
      chk("R10 idle dac", int'(dac), last_dac);
      chk("R10 idle result", int'(res), last_res);
   endtask

   // one conversion; poke > 0 re-asserts start at that cycle (R2)
   task automatic run(bit f, int p, int h, int v, int poke, string tag);
      int hh, clip, acc, top, bot, r, idx;
      @(negedge clk);
      fine = f; pre = 6'(p); slen = 4'(h); vin = v; start = 1'b1;
      hh = (h == 0) ? 1 : h;
      for (int i = 0; i < hh; i++) push(1, last_dac, 0, last_res, "R3 sample");
      push(0, last_dac, 0, last_res, "R4 setup");
      clip = (p > 15) ? 15 : p;                 // R8
      acc  = f ? (clip << 6) : 0;               // R4
      top  = f ? 5 : 9;
      bot  = f ? 0 : 5;                         // R6 R7
      for (int b = top; b >= bot; b--) begin
         push(0, acc | (1 << b), 0, last_res, (b == top) ? "R4 first trial" : tag);
         if ((acc | (1 << b)) <= v) acc = acc | (1 << b);   // R5
      end
      r = f ? (acc & 63) : (acc >> 5);
      push(0, acc, 1, r, "R9 done");
      last_dac = acc; last_res = r;
      idx = 0;
      while (q_dac.size() > 0) begin
         @(negedge clk);
         start = (poke > 0 && idx == poke);
         if (idx == 0) begin fine = ~f; pre = ~pre; end   // R2 late changes ignored
         chk({q_tag[0], " sample"}, int'(smp), int'(q_smp[0]));
         chk({q_tag[0], " dac"}, int'(dac), q_dac[0]);
         chk({q_tag[0], " done"}, int'(done), int'(q_done[0]));
         if (q_done[0]) chk("R9 result", int'(res), q_res[0]);
         else           chk({q_tag[0], " result"}, int'(res), q_res[0]);
         void'(q_smp.pop_front()); void'(q_dac.pop_front());
         void'(q_done.pop_front()); void'(q_res.pop_front());
         void'(q_tag.pop_front());
         idx++;
      end
      start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset dac", int'(dac), 0);
      chk("R1 reset result", int'(res), 0);
      chk("R1 reset sample", int'(smp), 0);
      chk("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      idle_check();
      run(0, 0, 3, 700, 0, "R6 coarse trial");
      idle_check();
      run(1, 10, 2, (10 << 6) + 37, 0, "R7 fine trial");
      idle_check();
      run(1, 40, 1, 1023, 0, "R8 clipped fine");
      run(1, 15, 4, 15 << 6, 0, "R8 edge fine");
      run(0, 0, 0, 1023, 0, "R3 zero sample coarse");
      run(0, 0, 2, 0, 0, "R6 coarse zero");
      run(1, 12, 3, 100, 0, "R7 fine below preload");
      run(0, 0, 5, 333, 3, "R2 start during coarse");
      idle_check();
      run(1, 3, 2, (3 << 6) + 50, 6, "R2 start during fine");
      run(1, 7, 15, (7 << 6) + 63, 0, "R5 long sample fine");
      idle_check();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule